// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block collects transfer-completion events from a multi-lane DMA engine and turns them into a single interrupt line toward a processor. Each event carries two items besides its valid strobe. The first is a request flag, which asks for an interrupt for that transfer. The second is a completion code, which names the bit of a pending register that the event should set. The lane on which an event arrives has no effect on which bit is set: only the code decides that. Several lanes may report in the same cycle, and every one of those events is recorded.

A second register holds one enable bit per pending bit. An enabled pending bit is a pending bit whose enable bit is 1. A small state machine watches the AND of the two registers. It issues a one-cycle interrupt pulse when that AND changes from all-zero to nonzero. It issues another pulse after a software clear if enabled pending bits remain, so that no completion goes unnoticed.

Software reaches both registers through a plain read/write port. Address 0 selects the pending register, and address 1 selects the enable register. A write to the pending register clears every bit where the data holds a 1, and leaves alone every bit where the data holds a 0. A write to the enable register stores the data as given.

Top module: `cmpl_irq_agg`

State machine states and transitions:
- `ST_IDLE`: no enabled pending bit. It moves to `ST_FIRE` when an enabled pending bit appears.
- `ST_FIRE`: drives the interrupt high for one cycle. It moves to `ST_HOLD` if enabled pending bits remain. Otherwise it moves to `ST_IDLE`.
- `ST_HOLD`: waits while enabled pending bits remain. It moves to `ST_IDLE` when none remain. It moves to `ST_FIRE` when a clearing write was accepted in the previous cycle and enabled pending bits still remain.

## Requirements
- R1: After reset, the pending register reads 0, the enable register reads 0 and `irq_o` is 0.
- R2: An event with its request flag at 1 and code n sets pending bit n at the next clock edge. This holds on any lane.
- R3: An event with its request flag at 0 changes no pending bit.
- R4: Events on different lanes in the same cycle, each with its own code, all set their pending bits at the same edge.
- R5: A write to address 0 clears each pending bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged. Such a write never sets a bit.
- R6: When an event sets bit n in the same cycle that a write clears bit n, bit n ends up set. Other bits in the same write are still cleared.
- R7: The enable register at address 1 stores the written 16-bit value, and it reads back that value. Reads are combinational from `addr_i`.
- R8: When the AND of the pending and enable registers goes from zero to nonzero, `irq_o` is high for exactly one cycle. This starts in the second cycle after the edge that updated the register.
- R9: While the enabled pending bits stay nonzero and no clearing write occurs, no further pulse is issued. This applies even when more events arrive.
- R10: After a clearing write (address 0, nonzero data) that leaves enabled pending bits set, a new one-cycle pulse starts in the second cycle after that write's edge. If the write leaves no enabled pending bits, no pulse is issued.
- R11: Pending bits whose enable bit is 0 never cause a pulse. Setting their enable bit later does cause a pulse, as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_vld_i | input | LANES | Completion event valid, one bit per lane |
| evt_req_i | input | LANES | Interrupt request flag, one bit per lane |
| evt_code_i | input | LANES*CODE_W | Completion code per lane; lane k occupies bits [k*CODE_W +: CODE_W] |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 pending, 1 enable |
| wdata_i | input | PEND_W | Write data |
| rdata_o | output | PEND_W | Read data of the selected register |
| irq_o | output | 1 | Interrupt pulse to the CPU |

## Verification
Register effects are due one edge after the stimulus. The bench drives inputs on the falling edge and reads `rdata_o` on the next falling edge, one edge later. An interrupt pulse is due two edges after its cause: one edge updates the register and the next edge moves the state machine into `ST_FIRE`. The bench therefore checks that `irq_o` is still low one falling edge after the stimulus, high on the next falling edge and low again on the one after. A pulse counter sampled on falling edges shows that no extra pulse appears during the waiting windows of R9 and R11.

// File: rtl/cia_pkg.sv
`timescale 1ns/1ps
package cia_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_HOLD = 2'd2
    } irq_state_e;

    localparam logic ADDR_PEND = 1'b0;
    localparam logic ADDR_EN   = 1'b1;
endpackage

// File: rtl/cia_evt_decode.sv
`timescale 1ns/1ps
module cia_evt_decode #(
    parameter int LANES  = 4,
    parameter int PEND_W = 16,
    parameter int CODE_W = 4
) (
    input  logic [LANES-1:0]        vld_i,
    input  logic [LANES-1:0]        req_i,
    input  logic [LANES*CODE_W-1:0] code_i,
    output logic [PEND_W-1:0]       set_o
);
    logic [PEND_W-1:0] lane_mask [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [CODE_W-1:0] code;
        assign code = code_i[g*CODE_W +: CODE_W];
        assign lane_mask[g] = (vld_i[g] && req_i[g]) ? (PEND_W'(1) << code) : '0;
    end

    always_comb begin
        set_o = '0;
        for (int k = 0; k < LANES; k++) begin
            set_o = set_o | lane_mask[k];
        end
    end
endmodule

// File: rtl/cia_regs.sv
`timescale 1ns/1ps
module cia_regs
    import cia_pkg::*;
#(
    parameter int PEND_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [PEND_W-1:0] set_i,
    input  logic              wr_en_i,
    input  logic              addr_i,
    input  logic [PEND_W-1:0] wdata_i,
    output logic [PEND_W-1:0] pend_o,
    output logic [PEND_W-1:0] en_o,
    output logic [PEND_W-1:0] rdata_o,
    output logic              clr_hit_o
);
    logic [PEND_W-1:0] pend_q, pend_d;
    logic [PEND_W-1:0] en_q, en_d;
    logic [PEND_W-1:0] clr_mask;

    always_comb begin
        clr_mask = (wr_en_i && addr_i == ADDR_PEND) ? wdata_i : '0;
        pend_d   = (pend_q & ~clr_mask) | set_i;
        en_d     = (wr_en_i && addr_i == ADDR_EN) ? wdata_i : en_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= pend_d;
            en_q   <= en_d;
        end
    end

    assign clr_hit_o = |clr_mask;
    assign pend_o    = pend_q;
    assign en_o      = en_q;
    assign rdata_o   = (addr_i == ADDR_EN) ? en_q : pend_q;
endmodule

// File: rtl/cia_irq_fsm.sv
`timescale 1ns/1ps
module cia_irq_fsm
    import cia_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic active_i,
    input  logic clr_hit_i,
    output logic irq_o
);
    irq_state_e state_q, state_d;
    logic       clr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            clr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            clr_q   <= clr_hit_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (active_i) state_d = ST_FIRE;
            end
            ST_FIRE: begin
                state_d = active_i ? ST_HOLD : ST_IDLE;
            end
            ST_HOLD: begin
                if (!active_i)  state_d = ST_IDLE;
                else if (clr_q) state_d = ST_FIRE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_o = (state_q == ST_FIRE);
    end
endmodule

// File: rtl/cmpl_irq_agg.sv
`timescale 1ns/1ps
module cmpl_irq_agg #(
    parameter int LANES  = 4,
    parameter int PEND_W = 16,
    localparam int CODE_W = $clog2(PEND_W)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [LANES-1:0]        evt_vld_i,
    input  logic [LANES-1:0]        evt_req_i,
    input  logic [LANES*CODE_W-1:0] evt_code_i,
    input  logic                    wr_en_i,
    input  logic                    addr_i,
    input  logic [PEND_W-1:0]       wdata_i,
    output logic [PEND_W-1:0]       rdata_o,
    output logic                    irq_o
);
    logic [PEND_W-1:0] set_mask;
    logic [PEND_W-1:0] pend_q;
    logic [PEND_W-1:0] en_q;
    logic              clr_hit;
    logic              active;

    cia_evt_decode #(
        .LANES (LANES),
        .PEND_W(PEND_W),
        .CODE_W(CODE_W)
    ) dec_i (
        .vld_i (evt_vld_i),
        .req_i (evt_req_i),
        .code_i(evt_code_i),
        .set_o (set_mask)
    );

    cia_regs #(
        .PEND_W(PEND_W)
    ) regs_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (set_mask),
        .wr_en_i  (wr_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .pend_o   (pend_q),
        .en_o     (en_q),
        .rdata_o  (rdata_o),
        .clr_hit_o(clr_hit)
    );

    assign active = |(pend_q & en_q);

    cia_irq_fsm fsm_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .active_i (active),
        .clr_hit_i(clr_hit),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/cia_chk.sv
`timescale 1ns/1ps
module cia_chk #(
    parameter int PEND_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PEND_W-1:0] pend,
    input logic [PEND_W-1:0] en,
    input logic [PEND_W-1:0] set_mask,
    input logic              wr,
    input logic              addr,
    input logic [PEND_W-1:0] wdata,
    input logic              irq
);
    logic act;
    assign act = |(pend & en);

    AST_SET_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((pend & $past(set_mask)) == $past(set_mask))); // R6

    AST_CLEAR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 1'b0 && set_mask == '0) |=> ((pend & $past(wdata)) == '0)); // R5

    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 1'b0) |=> ((pend & $past(pend & ~wdata)) == $past(pend & ~wdata))); // R5

    AST_PEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr && addr == 1'b0) && set_mask == '0) |=> $stable(pend)); // R3

    AST_EN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 1'b1) |=> (en == $past(wdata))); // R7

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8

    AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !$past(act)) |=> irq); // R8

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(act)); // R11
endmodule

bind cmpl_irq_agg cia_chk #(.PEND_W(PEND_W)) chk_i (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .pend    (pend_q),
    .en      (en_q),
    .set_mask(set_mask),
    .wr      (wr_en_i),
    .addr    (addr_i),
    .wdata   (wdata_i),
    .irq     (irq_o)
);

// File: tb/cmpl_irq_agg_tb.sv
`timescale 1ns/1ps
module cmpl_irq_agg_tb_top;
    localparam int LANES  = 4;
    localparam int PEND_W = 16;
    localparam int CODE_W = 4;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [LANES-1:0]        evt_vld = '0;
    logic [LANES-1:0]        evt_req = '0;
    logic [LANES*CODE_W-1:0] evt_code = '0;
    logic                    wr = 1'b0;
    logic                    addr = 1'b0;
    logic [PEND_W-1:0]       wdata = '0;
    logic [PEND_W-1:0]       rdata;
    logic                    irq;

    int n_chk = 0;
    int n_err = 0;
    int irq_cnt = 0;

    always #4 clk = ~clk;

    cmpl_irq_agg #(.LANES(LANES), .PEND_W(PEND_W)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .evt_vld_i (evt_vld),
        .evt_req_i (evt_req),
        .evt_code_i(evt_code),
        .wr_en_i   (wr),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .irq_o     (irq)
    );

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [PEND_W-1:0] v);
        addr = a;
        wr = 1'b0;
        #1;
        v = rdata;
    endtask

    task automatic wr_reg(input logic a, input logic [PEND_W-1:0] d);
        addr = a;
        wdata = d;
        wr = 1'b1;
        tick();
        wr = 1'b0;
        wdata = '0;
    endtask

    task automatic ev(input int lane, input int code, input logic req);
        evt_vld[lane] = 1'b1;
        evt_req[lane] = req;
        evt_code[lane*CODE_W +: CODE_W] = CODE_W'(code);
        tick();
        evt_vld = '0;
        evt_req = '0;
    endtask

    task automatic t_reset();
        logic [PEND_W-1:0] v;
        rd(1'b0, v); chk("R1 pending after reset", 32'(v), 32'h0);
        rd(1'b1, v); chk("R1 enable after reset", 32'(v), 32'h0);
        chk("R1 irq after reset", 32'(irq), 32'h0);
    endtask

    task automatic t_single();
        logic [PEND_W-1:0] v;
        int c0;
        c0 = irq_cnt;
        ev(2, 5, 1'b1);
        rd(1'b0, v); chk("R2 code 5 on lane 2", 32'(v), 32'h0020);
        ev(0, 3, 1'b0);
        rd(1'b0, v); chk("R3 request flag 0 ignored", 32'(v), 32'h0020);
        repeat (4) tick();
        #1 chk("R11 disabled bit gives no pulse", 32'(irq_cnt - c0), 32'h0);
        wr_reg(1'b0, 16'h0020);
        rd(1'b0, v); chk("R5 single clear", 32'(v), 32'h0);
    endtask

    task automatic t_multi();
        logic [PEND_W-1:0] v;
        evt_vld = 4'hF;
        evt_req = 4'hF;
        evt_code = {4'd15, 4'd9, 4'd4, 4'd1};
        tick();
        evt_vld = '0;
        evt_req = '0;
        rd(1'b0, v); chk("R4 four lanes in one cycle", 32'(v), 32'h8212);
        wr_reg(1'b0, 16'h0010);
        rd(1'b0, v); chk("R5 zeros leave bits", 32'(v), 32'h8202);
        wr_reg(1'b0, 16'hFFFF);
        rd(1'b0, v); chk("R5 clear all", 32'(v), 32'h0);
    endtask

    task automatic t_setwin();
        logic [PEND_W-1:0] v;
        ev(1, 2, 1'b1);
        evt_vld[3] = 1'b1;
        evt_req[3] = 1'b1;
        evt_code[3*CODE_W +: CODE_W] = 4'd7;
        wr_reg(1'b0, 16'h0084);
        evt_vld = '0;
        evt_req = '0;
        rd(1'b0, v); chk("R6 set beats clear", 32'(v), 32'h0080);
        wr_reg(1'b0, 16'hFFFF);
        rd(1'b0, v); chk("R5 cleanup", 32'(v), 32'h0);
    endtask

    task automatic t_enable();
        logic [PEND_W-1:0] v;
        wr_reg(1'b1, 16'hA5C3);
        rd(1'b1, v); chk("R7 enable readback", 32'(v), 32'hA5C3);
        rd(1'b0, v); chk("R7 pending untouched by enable write", 32'(v), 32'h0);
        wr_reg(1'b1, 16'h0000);
        rd(1'b1, v); chk("R7 enable cleared", 32'(v), 32'h0);
    endtask

    task automatic t_irq();
        int c0;
        wr_reg(1'b1, 16'h0240);
        c0 = irq_cnt;
        ev(0, 6, 1'b1);
        chk("R8 no pulse one edge after", 32'(irq), 32'h0);
        tick(); chk("R8 pulse two edges after", 32'(irq), 32'h1);
        tick(); chk("R8 pulse lasts one cycle", 32'(irq), 32'h0);
        ev(1, 9, 1'b1);
        ev(2, 6, 1'b1);
        repeat (4) tick();
        #1 chk("R9 no repeat while held", 32'(irq_cnt - c0), 32'h1);
        wr_reg(1'b0, 16'h0040);
        chk("R10 no pulse at clear edge", 32'(irq), 32'h0);
        tick(); chk("R10 repulse after clear", 32'(irq), 32'h1);
        tick(); chk("R10 repulse one cycle", 32'(irq), 32'h0);
        c0 = irq_cnt;
        wr_reg(1'b0, 16'h0200);
        repeat (4) tick();
        #1 chk("R10 no pulse when nothing left", 32'(irq_cnt - c0), 32'h0);
    endtask

    task automatic t_late_enable();
        int c0;
        wr_reg(1'b1, 16'h0000);
        c0 = irq_cnt;
        ev(3, 3, 1'b1);
        repeat (3) tick();
        #1 chk("R11 pending without enable", 32'(irq_cnt - c0), 32'h0);
        wr_reg(1'b1, 16'h0008);
        chk("R11 no pulse at enable edge", 32'(irq), 32'h0);
        tick(); chk("R11 pulse after enabling", 32'(irq), 32'h1);
        wr_reg(1'b0, 16'h0008);
    endtask

    initial begin
        #800000;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_single();
        t_multi();
        t_setwin();
        t_enable();
        t_irq();
        t_late_enable();
        repeat (2) tick();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule